// File: doc/BRIEF.md
# GCI Channel Slot Engine

This block sits on a serial GCI bus whose 125 µs frame is split into eight GCI channels, each four bytes long, for 256 bit positions per frame at 2.048 Mbit/s. A two-bit address picks one adjacent pair of GCI channels for this device. From the downstream line the block collects every byte that falls in that pair and delivers it as a parallel byte with a tag and a one-cycle valid strobe. On the upstream line it serialises the device's own eight bytes into the same positions. Outside those positions the upstream output is released.

The clock is the bus data clock, one bit per cycle. A frame-sync pulse, sampled on the same edge as the first bit of GCI channel 0, sets the bit position. Both lines carry each byte most significant bit first. Within a GCI channel the bytes come in a fixed order: B1, B2, monitor, then signaling/control. The B1 and B2 bytes of the first selected channel carry lines 1 and 2. Those of the second selected channel carry lines 3 and 4. Monitor handshaking and command decoding belong to other blocks.

Top module: `gci_slot_engine`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `up_oe`, `up_tx` and `rx_valid` are all low.
- R2: Until the first `fsync` is sampled, `rx_valid` and `up_oe` stay low whatever the state of `dn_rx` and `addr`.
- R3: An address value n selects GCI channels 2n and 2n+1, which are bit positions 64n to 64n+63. `rx_valid` pulses only for bytes that end inside that range. That gives eight pulses per frame, one for each of those bytes.
- R4: A byte whose last bit is sampled on edge k shows up on `rx_data` with `rx_valid` high during the cycle after edge k. The first bit received is the MSB. `rx_valid` is never high two cycles in a row.
- R5: With a byte, `rx_slot` is 0 for the first selected channel and 1 for the second. `rx_kind` is the byte's order within its channel: 0 = B1, 1 = B2, 2 = monitor, 3 = signaling/control. So B1/B2 with slot 0 carry lines 1/2, and with slot 1 they carry lines 3/4.
- R6: Once synchronised, `up_oe` is high exactly during the selected 64 bit positions. When `up_oe` is low, `up_tx` is 0.
- R7: During the cycle that ends with the edge sampling position p, `up_tx` carries the upstream bit for p, MSB first. The byte with slot s and kind k is read from `tx_bytes[(4*s+k)*8 +: 8]`.
- R8: `tx_bytes` is captured on the edge that samples position 255, and on the first `fsync` edge. Changing it part-way through a frame leaves the rest of that frame unchanged, and the new value is used from the next frame on.
- R9: An `fsync` seen at any position restarts the count at position 0 on that edge. Reception and transmission follow the new alignment from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus data clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | High on the edge that samples bit 0 of GCI channel 0 |
| addr | input | 2 | Selects GCI channels 2n and 2n+1 |
| dn_rx | input | 1 | Downstream serial data |
| tx_bytes | input | 64 | Eight outgoing bytes, indexed by (4*slot+kind) |
| up_tx | output | 1 | Upstream serial data |
| up_oe | output | 1 | Upstream drive enable |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_slot | output | 1 | 0 = first selected channel, 1 = second |
| rx_kind | output | 2 | 0 B1, 1 B2, 2 monitor, 3 signaling/control |

## Verification
A wrong position count appears at once, and on both lines: `up_oe` opens one or more bits off the selected window, and `rx_valid` pulses with a tag that does not match the byte's place. Both show up within the first byte boundary after the fault. A transmit capture on the wrong edge changes `up_tx` only once the bench changes `tx_bytes` mid-frame, so that case is driven on purpose. A missing realignment can only be seen after a frame is cut short. It then shows as strobes eight bits apart that no longer land on byte ends.

// File: rtl/gci_slot_pkg.sv
// Shared frame geometry for the GCI channel slot engine.
// Assumes power-of-two byte, channel and frame sizes, so that a bit
// position splits cleanly into group / slot / kind / bit fields.
package gci_slot_pkg;
    localparam int BYTE_W       = 8;
    localparam int BYTES_PER_CH = 4;
    localparam int NUM_CH       = 8;
    localparam int CH_PER_DEV   = 2;

    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int KIND_W   = $clog2(BYTES_PER_CH);
    localparam int SUB_W    = $clog2(CH_PER_DEV);
    localparam int GRP_W    = $clog2(NUM_CH / CH_PER_DEV);
    localparam int POS_W    = BIT_W + KIND_W + SUB_W + GRP_W;
    localparam int KIND_LSB = BIT_W;
    localparam int SUB_LSB  = KIND_LSB + KIND_W;
    localparam int GRP_LSB  = SUB_LSB + SUB_W;
    localparam int TX_W     = CH_PER_DEV * BYTES_PER_CH * BYTE_W;
    localparam int TXIDX_W  = $clog2(TX_W);

    typedef enum logic [KIND_W-1:0] {
        KIND_B1  = 2'd0,
        KIND_B2  = 2'd1,
        KIND_MON = 2'd2,
        KIND_SC  = 2'd3
    } byte_kind_e;
endpackage

// File: rtl/gci_frame_timer.sv
// Tracks the bit position inside the 256-bit frame.
// Assumes fsync is high on the edge that samples position 0.
// pos_o is the position sampled on this edge; nxt_o is the position
// carried on the line during the coming cycle.
module gci_frame_timer
    import gci_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] nxt_o,
    output logic             live_o,
    output logic             latch_o
);
    logic [POS_W-1:0] cnt_q;
    logic             synced_q;

    // Current and next position; fsync forces a restart at 0.
    always_comb begin
        pos_o   = fsync ? '0 : cnt_q + POS_W'(1);
        nxt_o   = pos_o + POS_W'(1);
        live_o  = synced_q | fsync;
        latch_o = (synced_q & (&pos_o)) | (fsync & ~synced_q);
    end

    // Position register and sticky sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            synced_q <= 1'b0;
        end else begin
            cnt_q    <= pos_o;
            synced_q <= synced_q | fsync;
        end
    end
endmodule

// File: rtl/gci_rx_deframer.sv
// Collects downstream bits and hands out each byte that ends inside
// the addressed channel pair, together with its slot and kind.
// Assumes MSB-first bytes aligned to multiples of BYTE_W positions.
module gci_rx_deframer
    import gci_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dn_rx,
    input  logic [GRP_W-1:0]  addr,
    input  logic [POS_W-1:0]  pos,
    input  logic              live,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [SUB_W-1:0]  rx_slot,
    output logic [KIND_W-1:0] rx_kind
);
    logic [BYTE_W-2:0] shift_q;
    logic              byte_done;
    byte_kind_e        kind_w;

    // A byte is complete on its last bit inside the selected pair.
    always_comb begin
        byte_done = live && (pos[POS_W-1:GRP_LSB] == addr) && (&pos[BIT_W-1:0]);
        kind_w    = byte_kind_e'(pos[SUB_LSB-1:KIND_LSB]);
    end

    // Shift register for the leading bits of the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[BYTE_W-3:0], dn_rx};
    end

    // Output byte, tags and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
            rx_kind  <= '0;
        end else begin
            rx_valid <= byte_done;
            if (byte_done) begin
                rx_data <= {shift_q, dn_rx};
                rx_slot <= pos[GRP_LSB-1:SUB_LSB];
                rx_kind <= kind_w;
            end
        end
    end
endmodule

// File: rtl/gci_tx_framer.sv
// Serialises the device's bytes into the addressed channel pair on
// the upstream line, one cycle ahead of the position being sampled.
// Assumes nxt is the position carried during the coming cycle.
module gci_tx_framer
    import gci_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TX_W-1:0]  tx_bytes,
    input  logic [GRP_W-1:0] addr,
    input  logic [POS_W-1:0] nxt,
    input  logic             live,
    input  logic             latch,
    output logic             up_tx,
    output logic             up_oe
);
    logic [TX_W-1:0]    tx_q;
    logic [TX_W-1:0]    src;
    logic [TXIDX_W-1:0] bit_idx;
    logic               drive;

    // Pick the source byte bit for the next position, MSB first.
    always_comb begin
        src     = latch ? tx_bytes : tx_q;
        bit_idx = {nxt[GRP_LSB-1:BIT_W], ~nxt[BIT_W-1:0]};
        drive   = live && (nxt[POS_W-1:GRP_LSB] == addr);
    end

    // Frame-wide copy of the outgoing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (latch) tx_q <= tx_bytes;
    end

    // Registered line output and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_tx <= 1'b0;
            up_oe <= 1'b0;
        end else begin
            up_oe <= drive;
            up_tx <= drive & src[bit_idx];
        end
    end
endmodule

// File: rtl/gci_slot_engine.sv
// Top of the GCI channel slot engine: frame timer, downstream
// deframer and upstream framer sharing one bit position.
// Assumes clk is the bus data clock and fsync is synchronous to it.
module gci_slot_engine
    import gci_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [GRP_W-1:0]  addr,
    input  logic              dn_rx,
    input  logic [TX_W-1:0]   tx_bytes,
    output logic              up_tx,
    output logic              up_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [SUB_W-1:0]  rx_slot,
    output logic [KIND_W-1:0] rx_kind
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt;
    logic             live;
    logic             latch;

    gci_frame_timer u_timer (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .pos_o(pos), .nxt_o(nxt), .live_o(live), .latch_o(latch)
    );

    gci_rx_deframer u_rx (
        .clk(clk), .rst_n(rst_n), .dn_rx(dn_rx), .addr(addr),
        .pos(pos), .live(live),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .rx_kind(rx_kind)
    );

    gci_tx_framer u_tx (
        .clk(clk), .rst_n(rst_n), .tx_bytes(tx_bytes), .addr(addr),
        .nxt(nxt), .live(live), .latch(latch),
        .up_tx(up_tx), .up_oe(up_oe)
    );
endmodule

// File: rtl/gci_slot_engine_chk.sv
// Port-level checker for gci_slot_engine. Keeps its own model of the
// sampled position and sync state, and checks strobes and the
// upstream window against that model.
module gci_slot_engine_chk
    import gci_slot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic [GRP_W-1:0]  addr,
    input logic              up_tx,
    input logic              up_oe,
    input logic              rx_valid,
    input logic [SUB_W-1:0]  rx_slot,
    input logic [KIND_W-1:0] rx_kind
);
    logic [POS_W-1:0] seen_pos_q;
    logic [POS_W-1:0] ahead_w;
    logic             seen_fs_q;

    // Model of the position sampled on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pos_q <= '0;
            seen_fs_q  <= 1'b0;
        end else begin
            seen_pos_q <= fsync ? '0 : seen_pos_q + POS_W'(1);
            seen_fs_q  <= seen_fs_q | fsync;
        end
    end

    assign ahead_w = seen_pos_q + POS_W'(1);

    p_quiet_presync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_fs_q |-> (!up_oe && !rx_valid));

    p_strobe_on_byte_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((&seen_pos_q[BIT_W-1:0]) &&
                      seen_pos_q[POS_W-1:GRP_LSB] == $past(addr)));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_tag_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_slot == seen_pos_q[GRP_LSB-1:SUB_LSB] &&
                      rx_kind == seen_pos_q[SUB_LSB-1:KIND_LSB]));

    p_oe_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_oe |-> (ahead_w[POS_W-1:GRP_LSB] == $past(addr)));

    p_released_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !up_oe |-> !up_tx);
endmodule

bind gci_slot_engine gci_slot_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .addr(addr),
    .up_tx(up_tx), .up_oe(up_oe), .rx_valid(rx_valid),
    .rx_slot(rx_slot), .rx_kind(rx_kind)
);

// File: tb/gci_slot_engine_bench.sv
module gci_slot_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        dn_rx = 1'b0;
    logic [63:0] tx_bytes = '0;
    logic        up_tx, up_oe, rx_valid;
    logic [7:0]  rx_data;
    logic [0:0]  rx_slot;
    logic [1:0]  rx_kind;

    int checks = 0;
    int failures = 0;

    // Bench model state, all describing the most recent clock edge.
    int          prev_pos = -1;
    int          prev_fid = 0;
    logic [1:0]  addr_edge = 2'd0;
    logic        seen = 1'b0;
    logic [63:0] tx_lat = '0;
    string       rx_tag = "R3";
    string       tx_tag = "R7";

    gci_slot_engine u_gci_slot_engine (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .addr(addr),
        .dn_rx(dn_rx), .tx_bytes(tx_bytes), .up_tx(up_tx), .up_oe(up_oe),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .rx_kind(rx_kind)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int fid, input int idx);
        return 8'(idx * 29 + fid * 53 + 8'h5A);
    endfunction

    // Check outputs against the model for a cycle carrying position q
    // (q = -1 when no position is meaningful).
    task automatic sample(input int q);
        logic [7:0] p;
        logic [7:0] pp;
        logic       exp_oe;
        logic       exp_v;
        if (!seen) begin
            check("R2", "up_oe before sync", 64'(up_oe), 64'd0);
            check("R2", "rx_valid before sync", 64'(rx_valid), 64'd0);
            return;
        end
        if (q >= 0 && prev_pos >= 0 && ((prev_pos + 1) % 256) == q) begin
            p = 8'(q);
            exp_oe = (p[7:6] == addr_edge);
            check("R6", "up_oe", 64'(up_oe), 64'(exp_oe));
            check(tx_tag, "up_tx", 64'(up_tx),
                  64'(exp_oe ? tx_lat[{p[5:3], ~p[2:0]}] : 1'b0));
        end
        if (prev_pos >= 0) begin
            pp = 8'(prev_pos);
            exp_v = (pp[7:6] == addr_edge) && (pp[2:0] == 3'd7);
            check(rx_tag, "rx_valid", 64'(rx_valid), 64'(exp_v));
            if (exp_v && rx_valid) begin
                check("R4", "rx_data", 64'(rx_data), 64'(byte_val(prev_fid, prev_pos / 8)));
                check("R5", "rx_slot", 64'(rx_slot), 64'(pp[5]));
                check("R5", "rx_kind", 64'(rx_kind), 64'(pp[4:3]));
            end
        end
    endtask

    // Drive positions 0..stop-1 of frame fid; optionally change addr at
    // the start and tx_bytes at position chg_at.
    task automatic run_frame(input int fid, input int stop, input logic [1:0] a,
                             input int chg_at, input logic [63:0] new_tx);
        logic [7:0] b;
        for (int q = 0; q < stop; q++) begin
            @(negedge clk);
            sample(q);
            if (q == 0) addr = a;
            if (q == chg_at) tx_bytes = new_tx;
            b = byte_val(fid, q / 8);
            fsync = (q == 0);
            dn_rx = b[7 - (q % 8)];
            if ((fsync && !seen) || (seen && q == 255)) tx_lat = tx_bytes;
            seen = seen | fsync;
            if (seen) begin
                prev_pos = q;
                prev_fid = fid;
            end
            addr_edge = addr;
        end
        fsync = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "up_oe in reset", 64'(up_oe), 64'd0);
        check("R1", "up_tx in reset", 64'(up_tx), 64'd0);
        check("R1", "rx_valid in reset", 64'(rx_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "up_oe after reset", 64'(up_oe), 64'd0);
        check("R1", "rx_valid after reset", 64'(rx_valid), 64'd0);
    endtask

    task automatic test_presync();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            sample(-1);
            dn_rx = 1'(i % 3);
            addr  = 2'(i);
            addr_edge = addr;
        end
    endtask

    task automatic test_addresses();
        tx_bytes = 64'hC3A5_0F96_1E2D_7B48;
        rx_tag = "R3";
        tx_tag = "R7";
        for (int a = 0; a < 4; a++) begin
            run_frame(10 + 2 * a, 256, 2'(a), -1, '0);
            run_frame(11 + 2 * a, 256, 2'(a), -1, '0);
        end
    endtask

    task automatic test_latch();
        tx_tag = "R8";
        run_frame(30, 256, 2'd3, 100, 64'h5AF0_3C96_E187_D24B);
        run_frame(31, 256, 2'd3, 40, 64'h0123_4567_89AB_CDEF);
        run_frame(32, 256, 2'd2, -1, '0);
        tx_tag = "R7";
    endtask

    task automatic test_realign();
        rx_tag = "R9";
        run_frame(40, 100, 2'd1, -1, '0);
        run_frame(41, 256, 2'd1, -1, '0);
        run_frame(42, 77, 2'd0, -1, '0);
        run_frame(43, 256, 2'd0, -1, '0);
        rx_tag = "R3";
    endtask

    initial begin
        test_reset();
        test_presync();
        test_addresses();
        test_latch();
        test_realign();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 10);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule